// File: doc/BRIEF.md
# Flash and Security Control Register Block

This block holds the control registers a microcontroller uses to guard its flash and its security fuses. It sits on a byte-wide special-function-register bus with an address, write data, a write strobe and a combinational read-data return. Four registers are decoded: a flash control register, a fuse-setup key register, a fuse-burn command register and a security register.

The control bits follow protection rules rather than plain storage. The program-space write enable steers external-memory moves into flash. It ignores writes while interrupts are enabled and clears itself after each flash byte. The mass-erase enable is write-only and is consumed when the flash controller starts an erase. The secure-lock bit can only be set. A fuse-burn start strobe is issued only when a setup key has been written first and the permanent-programming bit is set. Any other command value produces a stop strobe. A security pin level is synchronised and can be read back.

Top module: `fsr_top`

## Requirements
- R1: After reset every output is 0, and every register reads 0 (key-register and command-register reads are always 0).
- R2: With the interrupt-enable input low, a write to the flash control register (address 0x10) sets the program-write enable to data bit 0 on the next cycle. That bit reads back at bit 0.
- R3: While the interrupt-enable input is high, writes do not change the program-write enable.
- R4: A byte-written pulse clears the program-write enable on the next cycle. The pulse wins over a write in the same cycle.
- R5: Data bit 1 of a flash control write loads the mass-erase enable. This bit always reads 0. An erase-start pulse clears it on the next cycle and wins over a write in the same cycle.
- R6: Writing 1 to bit 6 of the flash control register sets the secure-lock output. Bit 6 reads back the lock state. Writing 0 never clears it; only reset does.
- R7: Writing 0x54 to the key register (address 0x11) arms fuse setup. Writing any other value to it disarms fuse setup.
- R8: Writing 0xA6 to the command register (address 0x12) gives a one-cycle start strobe on the next cycle, but only if fuse setup is armed and the permanent-programming bit is 1. Otherwise no strobe of either kind is produced.
- R9: Writing any value other than 0xA6 to the command register gives a one-cycle stop strobe on the next cycle. Start and stop are never high together.
- R10: In the security register (address 0x13), bit 7 (permanent programming) and bits 1:0 (security mode) are read/write and drive their outputs. Bit 5 reads the security pin after a two-flop synchronizer. All other bits read 0.
- R11: Reads of undefined addresses return 0, and writes to them change no output or register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 16 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_rdata | output | 8 | Read data for bus_addr |
| irq_en_i | input | 1 | Interrupts globally enabled |
| byte_done_i | input | 1 | Flash controller wrote one byte |
| erase_start_i | input | 1 | Flash controller accepted a mass erase |
| sec_pin_i | input | 1 | Asynchronous security pin level |
| prog_wr_en_o | output | 1 | Route external-memory moves to flash |
| mass_erase_en_o | output | 1 | Mass erase permitted |
| secure_lock_o | output | 1 | Block external reads of flash and program RAM |
| fuse_start_o | output | 1 | One-cycle fuse-burn start strobe |
| fuse_stop_o | output | 1 | One-cycle fuse-burn stop strobe |
| perm_prog_o | output | 1 | Permanent fuse programming enabled |
| sec_mode_o | output | 2 | Security mode setting |

## Verification
The bench builds the block with its default address parameters: 16-bit addresses with the four registers at 0x10 to 0x13. This lets it mix defined and undefined addresses with equal ease. Random sequences interleave interrupt-enable, byte-written and erase-start pulses with register writes. This reaches the same-cycle priority cases, and the key values 0xA6 and 0x54 are drawn with raised weight so that armed and unarmed burn attempts both occur.

// File: rtl/fsr_pkg.sv
// Package: shared constants for the flash and security register block.
// Assumes a byte-wide register bus.
package fsr_pkg;
    localparam int unsigned DATA_W    = 8;
    localparam logic [7:0]  KEY_SETUP = 8'h54;
    localparam logic [7:0]  CMD_BURN  = 8'hA6;
endpackage

// File: rtl/fsr_flash_ctl.sv
// Flash control bits: program-write enable, mass-erase enable, secure lock.
// Assumes wr_i is already qualified by the address decode of this register.
module fsr_flash_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_i,
    input  logic d_pwe_i,
    input  logic d_mee_i,
    input  logic d_lock_i,
    input  logic irq_en_i,
    input  logic byte_done_i,
    input  logic erase_start_i,
    output logic pwe_o,
    output logic mee_o,
    output logic lock_o
);
    logic pwe_q, mee_q, lock_q;

    // Program-write enable: write only with interrupts off, cleared per byte.
    always_ff @(posedge clk) begin
        if (!rst_n)                 pwe_q <= 1'b0;
        else if (byte_done_i)       pwe_q <= 1'b0;
        else if (wr_i && !irq_en_i) pwe_q <= d_pwe_i;
    end

    // Mass-erase enable: loaded by write, consumed by an erase start.
    always_ff @(posedge clk) begin
        if (!rst_n)             mee_q <= 1'b0;
        else if (erase_start_i) mee_q <= 1'b0;
        else if (wr_i)          mee_q <= d_mee_i;
    end

    // Secure lock: set-only until reset.
    always_ff @(posedge clk) begin
        if (!rst_n)               lock_q <= 1'b0;
        else if (wr_i && d_lock_i) lock_q <= 1'b1;
    end

    assign pwe_o  = pwe_q;
    assign mee_o  = mee_q;
    assign lock_o = lock_q;

    // R3: interrupts enabled and no byte pulse leave the enable unchanged
    p_pwe_hold_irq_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_en_i && !byte_done_i) |=> $stable(pwe_q));
    // R4: a flash byte always clears the enable
    p_pwe_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        byte_done_i |=> !pwe_q);
    // R5: an erase start consumes the mass-erase enable
    p_mee_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        erase_start_i |=> !mee_q);
    // R6: once set, the lock stays set
    p_lock_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        lock_q |=> lock_q);
endmodule

// File: rtl/fsr_fuse_ctl.sv
// Fuse setup key and burn command decoder producing start/stop strobes.
// Assumes perm_i comes from the security register and writes are pre-decoded.
module fsr_fuse_ctl
    import fsr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              key_wr_i,
    input  logic              cmd_wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              perm_i,
    output logic              start_o,
    output logic              stop_o
);
    logic arm_q, start_q, stop_q;

    // Arm flag follows the last value written to the key register.
    always_ff @(posedge clk) begin
        if (!rst_n)        arm_q <= 1'b0;
        else if (key_wr_i) arm_q <= (wdata_i == KEY_SETUP);
    end

    // One-cycle strobes decoded from a command write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= 1'b0;
            stop_q  <= 1'b0;
        end else begin
            start_q <= cmd_wr_i && (wdata_i == CMD_BURN) && arm_q && perm_i;
            stop_q  <= cmd_wr_i && (wdata_i != CMD_BURN);
        end
    end

    assign start_o = start_q;
    assign stop_o  = stop_q;

    // R8: a start strobe requires armed setup and permanent programming
    p_start_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
        start_q |-> $past(arm_q && perm_i && cmd_wr_i));
    // R9: strobes are mutually exclusive
    p_strobe_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(start_q && stop_q));
    // R9: strobes last a single cycle without a new command write
    p_stop_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_q && !cmd_wr_i) |=> !stop_q);
endmodule

// File: rtl/fsr_sec_reg.sv
// Security register: permanent-programming bit, mode bits, synced pin.
// Assumes sec_pin_i is asynchronous to clk.
module fsr_sec_reg (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_i,
    input  logic       d_perm_i,
    input  logic [1:0] d_mode_i,
    input  logic       sec_pin_i,
    output logic       perm_o,
    output logic [1:0] mode_o,
    output logic       pin_o
);
    localparam int unsigned SYNC_N = 2;
    logic       perm_q;
    logic [1:0] mode_q;
    logic [SYNC_N-1:0] sync_q;

    // Read/write security bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            perm_q <= 1'b0;
            mode_q <= 2'b00;
        end else if (wr_i) begin
            perm_q <= d_perm_i;
            mode_q <= d_mode_i;
        end
    end

    // Two-flop synchronizer on the security pin.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_N-2:0], sec_pin_i};
    end

    assign perm_o = perm_q;
    assign mode_o = mode_q;
    assign pin_o  = sync_q[SYNC_N-1];

    // R10: without a write the security bits hold
    p_sec_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_i |=> ($stable(perm_q) && $stable(mode_q)));
endmodule

// File: rtl/fsr_top.sv
// Flash and security control register block top: address decode, read mux.
// Assumes one register access per cycle; read data is combinational.
module fsr_top
    import fsr_pkg::*;
#(
    parameter int unsigned        ADDR_W    = 16,
    parameter logic [ADDR_W-1:0]  ADDR_FCTL = 16'h0010,
    parameter logic [ADDR_W-1:0]  ADDR_KEY  = 16'h0011,
    parameter logic [ADDR_W-1:0]  ADDR_CMD  = 16'h0012,
    parameter logic [ADDR_W-1:0]  ADDR_SEC  = 16'h0013
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_we,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              irq_en_i,
    input  logic              byte_done_i,
    input  logic              erase_start_i,
    input  logic              sec_pin_i,
    output logic              prog_wr_en_o,
    output logic              mass_erase_en_o,
    output logic              secure_lock_o,
    output logic              fuse_start_o,
    output logic              fuse_stop_o,
    output logic              perm_prog_o,
    output logic [1:0]        sec_mode_o
);
    logic wr_fctl, wr_key, wr_cmd, wr_sec;
    logic pin_s;

    assign wr_fctl = bus_we && (bus_addr == ADDR_FCTL);
    assign wr_key  = bus_we && (bus_addr == ADDR_KEY);
    assign wr_cmd  = bus_we && (bus_addr == ADDR_CMD);
    assign wr_sec  = bus_we && (bus_addr == ADDR_SEC);

    fsr_flash_ctl u_flash (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_i         (wr_fctl),
        .d_pwe_i      (bus_wdata[0]),
        .d_mee_i      (bus_wdata[1]),
        .d_lock_i     (bus_wdata[6]),
        .irq_en_i     (irq_en_i),
        .byte_done_i  (byte_done_i),
        .erase_start_i(erase_start_i),
        .pwe_o        (prog_wr_en_o),
        .mee_o        (mass_erase_en_o),
        .lock_o       (secure_lock_o)
    );

    fsr_fuse_ctl u_fuse (
        .clk     (clk),
        .rst_n   (rst_n),
        .key_wr_i(wr_key),
        .cmd_wr_i(wr_cmd),
        .wdata_i (bus_wdata),
        .perm_i  (perm_prog_o),
        .start_o (fuse_start_o),
        .stop_o  (fuse_stop_o)
    );

    fsr_sec_reg u_sec (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_i     (wr_sec),
        .d_perm_i (bus_wdata[7]),
        .d_mode_i (bus_wdata[1:0]),
        .sec_pin_i(sec_pin_i),
        .perm_o   (perm_prog_o),
        .mode_o   (sec_mode_o),
        .pin_o    (pin_s)
    );

    // Read mux: write-only and undefined bits return 0.
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_FCTL)
            bus_rdata = {1'b0, secure_lock_o, 5'b0, prog_wr_en_o};
        else if (bus_addr == ADDR_SEC)
            bus_rdata = {perm_prog_o, 1'b0, pin_s, 3'b0, sec_mode_o};
    end

    // R11: undefined addresses read as zero
    p_undef_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr != ADDR_FCTL && bus_addr != ADDR_SEC) |-> (bus_rdata == '0));
    // R5: mass-erase enable is never visible on the read path
    p_mee_hidden_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rdata[1] || (bus_addr == ADDR_SEC));
endmodule

// File: tb/fsr_top_tb_top.sv
// Bench for fsr_top: directed corners plus seeded random against a model.
module fsr_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_rdata;
    logic        irq_en_i = 1'b0, byte_done_i = 1'b0, erase_start_i = 1'b0, sec_pin_i = 1'b0;
    logic        prog_wr_en_o, mass_erase_en_o, secure_lock_o;
    logic        fuse_start_o, fuse_stop_o, perm_prog_o;
    logic [1:0]  sec_mode_o;

    int checks = 0;
    int errors = 0;

    // model state
    logic m_pwe, m_mee, m_lock, m_arm, m_perm, m_start, m_stop;
    logic [1:0] m_mode;

    always #5 clk = ~clk;

    fsr_top dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_rdata(bus_rdata), .irq_en_i(irq_en_i),
        .byte_done_i(byte_done_i), .erase_start_i(erase_start_i),
        .sec_pin_i(sec_pin_i), .prog_wr_en_o(prog_wr_en_o),
        .mass_erase_en_o(mass_erase_en_o), .secure_lock_o(secure_lock_o),
        .fuse_start_o(fuse_start_o), .fuse_stop_o(fuse_stop_o),
        .perm_prog_o(perm_prog_o), .sec_mode_o(sec_mode_o)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_fctl();
        return {1'b0, m_lock, 5'b0, m_pwe};
    endfunction

    function automatic logic [7:0] exp_outs();
        return {m_pwe, m_mee, m_lock, m_start, m_stop, m_perm, m_mode};
    endfunction

    function automatic logic [7:0] act_outs();
        return {prog_wr_en_o, mass_erase_en_o, secure_lock_o, fuse_start_o,
                fuse_stop_o, perm_prog_o, sec_mode_o};
    endfunction

    task automatic model_reset();
        m_pwe = 0; m_mee = 0; m_lock = 0; m_arm = 0; m_perm = 0;
        m_start = 0; m_stop = 0; m_mode = 2'b00;
    endtask

    // Update model for one edge using the inputs currently driven.
    task automatic model_step();
        logic wf, wk, wc, ws;
        wf = bus_we && bus_addr == 16'h0010;
        wk = bus_we && bus_addr == 16'h0011;
        wc = bus_we && bus_addr == 16'h0012;
        ws = bus_we && bus_addr == 16'h0013;
        m_start = wc && bus_wdata == 8'hA6 && m_arm && m_perm;
        m_stop  = wc && bus_wdata != 8'hA6;
        if (byte_done_i) m_pwe = 0; else if (wf && !irq_en_i) m_pwe = bus_wdata[0];
        if (erase_start_i) m_mee = 0; else if (wf) m_mee = bus_wdata[1];
        if (wf && bus_wdata[6]) m_lock = 1;
        if (wk) m_arm = (bus_wdata == 8'h54);
        if (ws) begin m_perm = bus_wdata[7]; m_mode = bus_wdata[1:0]; end
    endtask

    // One cycle with given inputs; inputs driven at negedge, checked next negedge.
    task automatic cycle(input logic we, input logic [15:0] a, input logic [7:0] d,
                         input logic irq, input logic bd, input logic es);
        bus_we = we; bus_addr = a; bus_wdata = d;
        irq_en_i = irq; byte_done_i = bd; erase_start_i = es;
        @(posedge clk);
        model_step();
        @(negedge clk);
        bus_we = 0; byte_done_i = 0; erase_start_i = 0;
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        cycle(1'b1, a, d, irq_en_i, 1'b0, 1'b0);
    endtask

    task automatic rd(input string req, input logic [15:0] a, input logic [7:0] exp);
        bus_addr = a;
        #1;
        check(req, bus_rdata, exp);
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EC0_1234));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check("R1 outputs", act_outs(), 8'h00);
        rd("R1 fctl", 16'h0010, 8'h00);
        rd("R1 sec", 16'h0013, 8'h00);
        rd("R1 key", 16'h0011, 8'h00);
        // R2 set / clear pwe
        wr(16'h0010, 8'h01);
        check("R2 pwe set", {7'b0, prog_wr_en_o}, 8'h01);
        rd("R2 fctl read", 16'h0010, 8'h01);
        wr(16'h0010, 8'h00);
        check("R2 pwe clear", {7'b0, prog_wr_en_o}, 8'h00);
        // R3 irq blocks
        irq_en_i = 1; wr(16'h0010, 8'h01);
        check("R3 pwe ignored", {7'b0, prog_wr_en_o}, 8'h00);
        irq_en_i = 0; wr(16'h0010, 8'h01);
        irq_en_i = 1; wr(16'h0010, 8'h00);
        check("R3 pwe clear ignored", {7'b0, prog_wr_en_o}, 8'h01);
        irq_en_i = 0;
        // R4 byte done clears, wins over write
        cycle(1'b0, 16'h0010, 8'h00, 1'b0, 1'b1, 1'b0);
        check("R4 byte clears", {7'b0, prog_wr_en_o}, 8'h00);
        cycle(1'b1, 16'h0010, 8'h01, 1'b0, 1'b1, 1'b0);
        check("R4 byte wins", {7'b0, prog_wr_en_o}, 8'h00);
        // R5 mass erase
        wr(16'h0010, 8'h02);
        check("R5 mee set", {7'b0, mass_erase_en_o}, 8'h01);
        rd("R5 mee reads 0", 16'h0010, 8'h00);
        cycle(1'b0, 16'h0010, 8'h00, 1'b0, 1'b0, 1'b1);
        check("R5 mee consumed", {7'b0, mass_erase_en_o}, 8'h00);
        cycle(1'b1, 16'h0010, 8'h02, 1'b0, 1'b0, 1'b1);
        check("R5 erase wins", {7'b0, mass_erase_en_o}, 8'h00);
        // R8 burn without arm/perm
        wr(16'h0012, 8'hA6);
        check("R8 no strobe unarmed", {6'b0, fuse_start_o, fuse_stop_o}, 8'h00);
        wr(16'h0013, 8'h80);
        wr(16'h0012, 8'hA6);
        check("R8 no strobe perm only", {6'b0, fuse_start_o, fuse_stop_o}, 8'h00);
        // R7 arm then R8 start
        wr(16'h0011, 8'h54);
        rd("R7 key reads 0", 16'h0011, 8'h00);
        wr(16'h0012, 8'hA6);
        check("R8 start strobe", {6'b0, fuse_start_o, fuse_stop_o}, 8'h02);
        @(negedge clk);
        check("R8 single cycle", {6'b0, fuse_start_o, fuse_stop_o}, 8'h00);
        // R9 stop strobe
        wr(16'h0012, 8'h00);
        check("R9 stop strobe", {6'b0, fuse_start_o, fuse_stop_o}, 8'h01);
        // R7 disarm
        wr(16'h0011, 8'h55);
        wr(16'h0012, 8'hA6);
        check("R7 disarmed", {6'b0, fuse_start_o, fuse_stop_o}, 8'h00);
        // R10 security register
        wr(16'h0013, 8'hFF);
        rd("R10 sec read", 16'h0013, 8'h83);
        check("R10 mode out", {6'b0, sec_mode_o}, 8'h03);
        sec_pin_i = 1;
        @(negedge clk);
        rd("R10 pin after 1", 16'h0013, 8'h83);
        @(negedge clk);
        rd("R10 pin after 2", 16'h0013, 8'hA3);
        sec_pin_i = 0;
        repeat (2) @(negedge clk);
        // R6 lock sticky
        wr(16'h0010, 8'h40);
        check("R6 lock set", {7'b0, secure_lock_o}, 8'h01);
        wr(16'h0010, 8'h00);
        check("R6 lock stays", {7'b0, secure_lock_o}, 8'h01);
        rd("R6 lock read", 16'h0010, 8'h40);
        // R11 undefined address
        wr(16'h0014, 8'hFF);
        check("R11 no effect", act_outs(), exp_outs());
        rd("R11 undef read", 16'h0014, 8'h00);
        rd("R11 undef read2", 16'h00FF, 8'h00);
        // random phase: reset first to clear the lock
        rst_n = 0; @(negedge clk); rst_n = 1; model_reset();
        for (int i = 0; i < 3000; i++) begin
            logic [15:0] a;
            logic [7:0]  d;
            int sel;
            sel = $urandom_range(0, 4);
            a = 16'h0010 + 16'(sel);
            case ($urandom_range(0, 3))
                0: d = 8'hA6;
                1: d = 8'h54;
                default: d = 8'($urandom);
            endcase
            if (sel == 0 && $urandom_range(0, 7) != 0) d[6] = 1'b0;
            cycle($urandom_range(0, 3) != 0, a, d, $urandom_range(0, 1) == 1,
                  $urandom_range(0, 5) == 0, $urandom_range(0, 5) == 0);
            check("R2 R4 R5 R6 R8 R9 random outputs", act_outs(), exp_outs());
            if (i % 16 == 0) rd("R2 R10 random read", 16'h0010, exp_fctl());
        end
        rd("R10 random sec read", 16'h0013, {m_perm, 5'b0, m_mode});
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule